// File: doc/BRIEF.md
# Dual-Port Falling-Edge Interrupt Detector

This block raises one shared interrupt request for two 4-bit ports (eight pins in all) when any pin set as an input is pulled from high to low. Pins set as outputs are masked out. The pin levels must already be synchronized to the clock. The block also takes the per-pin direction bits, software writes to an enable flag and a request flag, and a strobe from the CPU that marks the interrupt as taken.

The detector does not detect edges pin by pin. It has a single armed state. One falling edge sets the request and disarms the detector. The detector arms again only after every participating input pin reads high at the same time. After reset it is disarmed, and it arms on the first clock where every input pin reads high. While it is disarmed, falling edges have no effect.

The interrupt output is the AND of the enable and request flags. Accepting the interrupt clears the enable flag and leaves the request flag as it was, so software clears the request itself.

Top module: `port_fall_irq`

## Requirements
- R1: While reset is low and right after it is released, `en_o`, `req_o` and `irq_o` are 0.
- R2: When the detector is armed, a high-to-low change on any pin whose direction bit is 0 (input), on either port, makes `req_o` 1 at the next clock edge. Pin index i belongs to port i/4.
- R3: A pin whose direction bit is 1 (output) cannot set the request, whatever its level does.
- R4: After a falling edge sets the request, any further falling edge is ignored, even if software has cleared the request, until all input pins have read high together.
- R5: Re-arming looks only at input pins. Output pins held low do not stop the detector from arming again.
- R6: Writing 0 through `req_wr_i`/`req_wdata_i` clears the request flag, and writing 1 sets it.
- R7: If a request write of 0 and a falling edge that triggers fall in the same cycle, the request ends up at 1.
- R8: `irq_o` is 1 exactly when both `en_o` and `req_o` are 1.
- R9: `accept_i` clears the enable flag at the next edge. It wins over an enable write in the same cycle and leaves the request flag unchanged.
- R10: After reset, if an input pin is low, no falling edge is taken until all input pins have been high.
- R11: Writing through `en_wr_i`/`en_wdata_i` sets or clears the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Synchronized pin levels, port 0 in bits 3:0 |
| dir_i | input | 8 | Direction per pin, 1 = output (masked) |
| en_wr_i | input | 1 | Write strobe for the enable flag |
| en_wdata_i | input | 1 | Value written to the enable flag |
| req_wr_i | input | 1 | Write strobe for the request flag |
| req_wdata_i | input | 1 | Value written to the request flag |
| accept_i | input | 1 | Interrupt taken by the CPU |
| en_o | output | 1 | Enable flag |
| req_o | output | 1 | Request flag |
| irq_o | output | 1 | Interrupt pending |

## Verification
Each flag has exactly one register between its inputs and the port. A pin change or a flag write applied in one cycle therefore shows up on `req_o`, `en_o` and `irq_o` after the next rising edge. The arming state takes one extra edge: a pattern with all inputs high must be held for one cycle before a falling edge can be taken. The driver applies each stimulus on the falling clock edge and queues the outputs it expects. The monitor samples a quarter period after the following rising edge, so each expected item is compared exactly one register stage after its stimulus.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int unsigned DEF_PORTS  = 2;
  localparam int unsigned DEF_PORT_W = 4;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } pin_dir_e;
endpackage

// File: rtl/pfi_edge_scan.sv
module pfi_edge_scan
  import pfi_pkg::*;
#(
  parameter int unsigned NUM_PORTS = DEF_PORTS,
  parameter int unsigned PORT_W    = DEF_PORT_W,
  localparam int unsigned NPINS    = NUM_PORTS * PORT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] dir_i,
  output logic             fall_any_o,
  output logic             all_high_o
);
  logic [NPINS-1:0]     prev_q;
  logic [NUM_PORTS-1:0] port_fall;
  logic [NUM_PORTS-1:0] port_high;

  // prev resets low so no edge is reported on the first cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] lvl, old, out_m;
    assign lvl   = pins_i[p*PORT_W +: PORT_W];
    assign old   = prev_q[p*PORT_W +: PORT_W];
    assign out_m = dir_i[p*PORT_W +: PORT_W];
    assign port_fall[p] = |(old & ~lvl & ~out_m);
    assign port_high[p] = &(lvl | out_m);
  end

  assign fall_any_o = |port_fall;
  assign all_high_o = &port_high;
endmodule

// File: rtl/pfi_arm.sv
module pfi_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_any_i,
  input  logic all_high_i,
  output logic trigger_o
);
  logic armed_q;

  assign trigger_o = armed_q & fall_any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (trigger_o)  armed_q <= 1'b0;
    else if (all_high_i) armed_q <= 1'b1;
  end

  assert_disarm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_o |=> !armed_q);
  assert_arm_needs_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(all_high_i));
endmodule

// File: rtl/pfi_flags.sv
module pfi_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trigger_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic req_wr_i,
  input  logic req_wdata_i,
  input  logic accept_i,
  output logic en_o,
  output logic req_o
);
  logic en_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_q <= 1'b0;
    else if (trigger_i) req_q <= 1'b1;
    else if (req_wr_i)  req_q <= req_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (accept_i) en_q <= 1'b0;
    else if (en_wr_i)  en_q <= en_wdata_i;
  end

  assign en_o  = en_q;
  assign req_o = req_q;

  assert_accept_clears_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !en_q);
  assert_edge_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_i |=> req_q);
  assert_req_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(trigger_i || (req_wr_i && req_wdata_i)));
endmodule

// File: rtl/port_fall_irq.sv
module port_fall_irq
  import pfi_pkg::*;
#(
  parameter int unsigned NUM_PORTS = DEF_PORTS,
  parameter int unsigned PORT_W    = DEF_PORT_W,
  localparam int unsigned NPINS    = NUM_PORTS * PORT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             req_wr_i,
  input  logic             req_wdata_i,
  input  logic             accept_i,
  output logic             en_o,
  output logic             req_o,
  output logic             irq_o
);
  logic fall_any, all_high, trigger;

  pfi_edge_scan #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .dir_i(dir_i),
    .fall_any_o(fall_any), .all_high_o(all_high)
  );

  pfi_arm u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_any_i(fall_any),
    .all_high_i(all_high), .trigger_o(trigger)
  );

  pfi_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .trigger_i(trigger),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .req_wr_i(req_wr_i), .req_wdata_i(req_wdata_i),
    .accept_i(accept_i), .en_o(en_o), .req_o(req_o)
  );

  assign irq_o = en_o & req_o;

  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o || !req_o) |-> !irq_o);
endmodule

// File: tb/port_fall_irq_bench.sv
module port_fall_irq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pins_i = 8'hFE;
  logic [7:0] dir_i = 8'h00;
  logic en_wr_i = 0, en_wdata_i = 0, req_wr_i = 0, req_wdata_i = 0, accept_i = 0;
  logic en_o, req_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit    chk;
    logic  xreq;
    logic  xen;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  port_fall_irq u_port_fall_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .dir_i(dir_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .req_wr_i(req_wr_i), .req_wdata_i(req_wdata_i),
    .accept_i(accept_i), .en_o(en_o), .req_o(req_o), .irq_o(irq_o)
  );

  task automatic cmp(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // monitor: one queued item per driven cycle, sampled after the next rising edge
  always @(posedge clk_i) begin
    #5;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      if (it.chk) begin
        cmp(it.tag, req_o, it.xreq, "req");
        cmp(it.tag, en_o, it.xen, "en");
        cmp(it.tag, irq_o, it.xreq & it.xen, "irq");
      end
    end
  end

  task automatic step(input logic [7:0] p, input logic [7:0] d,
                      input logic ew, input logic ewd,
                      input logic rw, input logic rwd, input logic acc,
                      input bit chk, input logic xr, input logic xe, input string tag);
    exp_t it;
    @(negedge clk_i);
    pins_i = p; dir_i = d;
    en_wr_i = ew; en_wdata_i = ewd;
    req_wr_i = rw; req_wdata_i = rwd; accept_i = acc;
    it.chk = chk; it.xreq = xr; it.xen = xe; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cmp("R1", req_o, 1'b0, "req in reset");
    cmp("R1", en_o, 1'b0, "en in reset");
    rst_ni = 1'b1;
    #1;
    cmp("R1", irq_o, 1'b0, "irq after release");
    // R10: pin0 low at reset, pin1 falls -> not armed
    step(8'hFE, 8'h00, 0,0, 0,0, 0, 0, 0,0, "");
    step(8'hFC, 8'h00, 0,0, 0,0, 0, 1, 0,0, "R10");
    step(8'hFF, 8'h00, 0,0, 0,0, 0, 1, 0,0, "R10");
    // R2: port 1 pin7 falls
    step(8'h7F, 8'h00, 0,0, 0,0, 0, 1, 1,0, "R2");
    // R6 clear, then R4 second edge ignored while still disarmed
    step(8'h7F, 8'h00, 0,0, 1,0, 0, 1, 0,0, "R6");
    step(8'h3F, 8'h00, 0,0, 0,0, 0, 1, 0,0, "R4");
    step(8'hFF, 8'h00, 0,0, 0,0, 0, 1, 0,0, "R4");
    // R2: port 0 pin3 falls after rearm
    step(8'hF7, 8'h00, 0,0, 0,0, 0, 1, 1,0, "R2");
    step(8'hFF, 8'h00, 0,0, 1,0, 0, 1, 0,0, "R6");
    // R3: pins 0-3 as outputs, they fall
    step(8'hFF, 8'h0F, 0,0, 0,0, 0, 0, 0,0, "");
    step(8'hF0, 8'h0F, 0,0, 0,0, 0, 1, 0,0, "R3");
    step(8'hE0, 8'h0F, 0,0, 0,0, 0, 1, 1,0, "R3");
    // R5: rearm with outputs held low
    step(8'hF0, 8'h0F, 0,0, 1,0, 0, 1, 0,0, "R5");
    step(8'hD0, 8'h0F, 0,0, 0,0, 0, 1, 1,0, "R5");
    // R7: clear write and edge together
    step(8'hF0, 8'h0F, 0,0, 1,0, 0, 1, 0,0, "R7");
    step(8'hB0, 8'h0F, 0,0, 1,0, 0, 1, 1,0, "R7");
    step(8'hF0, 8'h0F, 0,0, 1,0, 0, 1, 0,0, "R6");
    step(8'hF0, 8'h0F, 0,0, 1,1, 0, 1, 1,0, "R6");
    // R11 / R8 / R9
    step(8'hF0, 8'h0F, 1,1, 0,0, 0, 1, 1,1, "R11");
    step(8'hF0, 8'h0F, 1,1, 0,0, 1, 1, 1,0, "R9");
    step(8'hF0, 8'h0F, 1,1, 0,0, 0, 1, 1,1, "R11");
    step(8'hF0, 8'h0F, 0,0, 1,0, 0, 1, 0,1, "R8");
    step(8'hF0, 8'h0F, 1,0, 0,0, 0, 1, 0,0, "R11");
    step(8'hF0, 8'h0F, 0,0, 0,0, 0, 0, 0,0, "");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule